// File: doc/BRIEF.md
# Instruction Step Sequencer

This block is the control loop of a small instruction machine in which every instruction has the shape `(c, flag) = op(a, b)`. It fetches one instruction from a code ROM at the current program counter. It then runs four handshakes in a fixed order: resolve operand a, resolve operand b, perform the operation, and commit c. After the commit it either stops or moves the program counter on.

The block keeps the result and the flag of the last committed instruction as architectural state. It shows them to the operand unit, together with the step count, so that a later instruction can use them as operand sources. It does no arithmetic itself and holds no memory contents.

The next program counter comes from one of three rules. A jump relative to a register takes the low 32 bits of c plus a jump constant. A branch takes pc plus a taken constant when the flag is 1, or pc plus a fall-through constant when the flag is 0. Plain sequencing sets the taken and fall-through constants to the same value.

A run ends in one of two ways:
- **Success:** an instruction marked as final commits while pc equals the exit address.
- **Failure:** the run meets a halt opcode, an illegal or missing instruction, an access fault, the step budget, or a final instruction at the wrong address.

The status it leaves stays frozen until reset.

Top module: `step_sequencer`

## Requirements
- R1: During reset and on the first cycle after it, pc is BOOT_PC (default 0x1000), the step count is 0, the held result and flag are 0, and done is 0.
- R2: Each step raises its requests one at a time, in this order: ROM fetch, operand a (`opnd_sel`=0), operand b (`opnd_sel`=1), operation, commit. Each request stays high until its acknowledge. The operation receives exactly the resolved a and b, and the commit carries exactly the returned c.
- R3: The instruction word is {op[105:98], final[97], rel[96], kj[95:64], kt[63:32], kf[31:0]}. After a non-final commit, pc becomes c[31:0]+kj if rel=1. Otherwise it becomes pc+kt if the new flag is 1, or pc+kf if it is 0. All sums are modulo 2^32.
- R4: `prev_c` and `prev_flag` take the step's c and flag only on a fault-free commit acknowledge, and are stable otherwise.
- R5: The step count rises by exactly 1 per fault-free commit and by nothing else.
- R6: A final instruction stops the run after its commit, with no pc update. It sets success with code 0 if pc equals EXIT_PC (default 0x1100), and code 5 otherwise.
- R7: An acknowledged fetch of opcode 0x3F stops the run with code 1 before any operand request.
- R8: A fetch acknowledged with `rom_hit`=0, or an opcode of NUM_OPS (default 16) or above other than 0x3F, stops the run with code 2.
- R9: An acknowledge with `opnd_fault` or `wb_fault` high stops the run with code 3. The held result, flag, step count and pc are left unchanged.
- R10: When the step count equals MAX_STEPS before a final instruction, the run stops with code 4 and issues no further fetch.
- R11: Once done is 1, done, success and `err_code` hold until reset, and no request is raised. Success is 1 only with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_req | output | 1 | Instruction fetch request |
| rom_addr | output | 32 | Fetch address (current pc) |
| rom_ack | input | 1 | Fetch acknowledge |
| rom_hit | input | 1 | An instruction exists at the address |
| rom_data | input | 106 | Instruction word |
| inst_out | output | 106 | Instruction of the current step |
| opnd_req | output | 1 | Operand resolution request |
| opnd_sel | output | 1 | 0 = operand a, 1 = operand b |
| opnd_ack | input | 1 | Operand acknowledge |
| opnd_fault | input | 1 | Operand access fault |
| opnd_data | input | 64 | Resolved operand value |
| a_out | output | 64 | Resolved operand a (base for indirect b) |
| prev_c | output | 64 | Held result of the last committed step |
| prev_flag | output | 1 | Held flag of the last committed step |
| step_cnt | output | 32 | Completed instruction count |
| exe_req | output | 1 | Operation request |
| exe_op | output | 8 | Opcode for the operation unit |
| exe_a | output | 64 | Operand a |
| exe_b | output | 64 | Operand b |
| exe_ack | input | 1 | Operation acknowledge |
| exe_c | input | 64 | Operation result |
| exe_flag | input | 1 | Operation flag |
| wb_req | output | 1 | Result commit request |
| wb_data | output | 64 | Result to commit |
| wb_ack | input | 1 | Commit acknowledge |
| wb_fault | input | 1 | Commit access fault |
| pc_out | output | 32 | Current program counter |
| done | output | 1 | Run finished |
| success | output | 1 | Run finished at the exit address |
| err_code | output | 3 | 0 none, 1 halt, 2 invalid, 3 access, 4 step limit, 5 wrong exit |

## Verification
The bench's responders acknowledge at the falling edge after a request is seen, and the design acts on that acknowledge at the next rising edge. With prompt responders, each step therefore takes five cycles.

An expected fetch entry holds the address, step count and held result of that step. It is compared at the very falling edge where the fetch is acknowledged, because these values settle at the commit edge before that fetch. The operation inputs and the commit data are checked at the falling edge of their own handshakes.

The final status is compared at the first falling edge after done rises, which is one clock after the edge that met the terminating condition. It is checked again six cycles later to confirm that nothing moved.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

    localparam int ADDR_W = 32;
    localparam int XLEN   = 64;
    localparam int OP_W   = 8;
    localparam int STEP_W = 32;

    // Opcode reserved as a trap sentinel for unreachable code
    localparam logic [OP_W-1:0] OP_HALT = 8'h3F;

    // Instruction word; field order is decoded by the operand unit too
    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic              fin;   // stop after commit
        logic              rel;   // next pc from result plus kj
        logic [ADDR_W-1:0] kj;    // register-relative jump constant
        logic [ADDR_W-1:0] kt;    // offset when flag is 1
        logic [ADDR_W-1:0] kf;    // offset when flag is 0
    } inst_t;

    localparam int INST_W = $bits(inst_t);

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_HALT    = 3'd1,
        ERR_INVALID = 3'd2,
        ERR_ACCESS  = 3'd3,
        ERR_STEPS   = 3'd4,
        ERR_EXIT    = 3'd5
    } err_t;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_OPA,
        ST_OPB,
        ST_EXEC,
        ST_COMMIT,
        ST_STOP
    } state_t;

    function automatic logic [ADDR_W-1:0] addr_add(input logic [ADDR_W-1:0] base,
                                                   input logic [ADDR_W-1:0] ofs);
        return base + ofs;
    endfunction

endpackage

// File: rtl/seqr_decode.sv
module seqr_decode import seqr_pkg::*; #(
    parameter int NUM_OPS = 16
) (
    input  logic              hit,
    input  logic [INST_W-1:0] word,
    output inst_t             inst,
    output err_t              fault
);

    always_comb begin
        inst  = inst_t'(word);
        fault = ERR_NONE;
        if (!hit) begin
            fault = ERR_INVALID;
        end else if (inst.op == OP_HALT) begin
            fault = ERR_HALT;
        end else if (int'(inst.op) >= NUM_OPS) begin
            fault = ERR_INVALID;
        end
    end

endmodule

// File: rtl/seqr_next_pc.sv
module seqr_next_pc import seqr_pkg::*; (
    input  logic [ADDR_W-1:0] pc,
    input  inst_t             inst,
    input  logic [ADDR_W-1:0] c_low,
    input  logic              flag,
    output logic [ADDR_W-1:0] pc_next
);

    logic [ADDR_W-1:0] tgt_rel;
    logic [ADDR_W-1:0] tgt_taken;
    logic [ADDR_W-1:0] tgt_fall;

    assign tgt_rel   = addr_add(c_low, inst.kj);
    assign tgt_taken = addr_add(pc, inst.kt);
    assign tgt_fall  = addr_add(pc, inst.kf);

    always_comb begin
        if (inst.rel) begin
            pc_next = tgt_rel;
        end else if (flag) begin
            pc_next = tgt_taken;
        end else begin
            pc_next = tgt_fall;
        end
    end

endmodule

// File: rtl/seqr_status.sv
module seqr_status import seqr_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  err_t code,
    output logic done,
    output logic success,
    output err_t code_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            success <= 1'b0;
            code_q  <= ERR_NONE;
        end else if (set && !done) begin
            done    <= 1'b1;
            success <= (code == ERR_NONE);
            code_q  <= code;
        end
    end

endmodule

// File: rtl/step_sequencer.sv
module step_sequencer import seqr_pkg::*; #(
    parameter logic [ADDR_W-1:0] BOOT_PC   = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] EXIT_PC   = 32'h0000_1100,
    parameter int                MAX_STEPS = 1024,
    parameter int                NUM_OPS   = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic              rom_req,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic              rom_ack,
    input  logic              rom_hit,
    input  logic [INST_W-1:0] rom_data,
    output logic [INST_W-1:0] inst_out,
    output logic              opnd_req,
    output logic              opnd_sel,
    input  logic              opnd_ack,
    input  logic              opnd_fault,
    input  logic [XLEN-1:0]   opnd_data,
    output logic [XLEN-1:0]   a_out,
    output logic [XLEN-1:0]   prev_c,
    output logic              prev_flag,
    output logic [STEP_W-1:0] step_cnt,
    output logic              exe_req,
    output logic [OP_W-1:0]   exe_op,
    output logic [XLEN-1:0]   exe_a,
    output logic [XLEN-1:0]   exe_b,
    input  logic              exe_ack,
    input  logic [XLEN-1:0]   exe_c,
    input  logic              exe_flag,
    output logic              wb_req,
    output logic [XLEN-1:0]   wb_data,
    input  logic              wb_ack,
    input  logic              wb_fault,
    output logic [ADDR_W-1:0] pc_out,
    output logic              done,
    output logic              success,
    output logic [2:0]        err_code
);

    localparam logic [STEP_W-1:0] STEP_LIMIT = STEP_W'(MAX_STEPS);

    state_t            st_q, st_d;
    logic [ADDR_W-1:0] pc_q, pc_nxt;
    inst_t             inst_q, inst_dec;
    err_t              dec_err;
    logic [XLEN-1:0]   a_q, b_q, c_q, hold_c_q;
    logic              f_q, hold_f_q;
    logic [STEP_W-1:0] step_q;
    logic              budget_out;
    logic              stop_set;
    err_t              stop_code;
    err_t              status_code;

    seqr_decode #(.NUM_OPS(NUM_OPS)) u_dec (
        .hit   (rom_hit),
        .word  (rom_data),
        .inst  (inst_dec),
        .fault (dec_err)
    );

    seqr_next_pc u_npc (
        .pc      (pc_q),
        .inst    (inst_q),
        .c_low   (c_q[ADDR_W-1:0]),
        .flag    (f_q),
        .pc_next (pc_nxt)
    );

    seqr_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .set     (stop_set),
        .code    (stop_code),
        .done    (done),
        .success (success),
        .code_q  (status_code)
    );

    assign budget_out = (step_q == STEP_LIMIT);

    // Step control: one handshake at a time in architectural order
    always_comb begin
        st_d      = st_q;
        stop_set  = 1'b0;
        stop_code = ERR_NONE;
        case (st_q)
            ST_FETCH: begin
                if (budget_out) begin
                    stop_set  = 1'b1;
                    stop_code = ERR_STEPS;
                    st_d      = ST_STOP;
                end else if (rom_ack) begin
                    if (dec_err != ERR_NONE) begin
                        stop_set  = 1'b1;
                        stop_code = dec_err;
                        st_d      = ST_STOP;
                    end else begin
                        st_d = ST_OPA;
                    end
                end
            end
            ST_OPA, ST_OPB: begin
                if (opnd_ack) begin
                    if (opnd_fault) begin
                        stop_set  = 1'b1;
                        stop_code = ERR_ACCESS;
                        st_d      = ST_STOP;
                    end else begin
                        st_d = (st_q == ST_OPA) ? ST_OPB : ST_EXEC;
                    end
                end
            end
            ST_EXEC: begin
                if (exe_ack) begin
                    st_d = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                if (wb_ack) begin
                    if (wb_fault) begin
                        stop_set  = 1'b1;
                        stop_code = ERR_ACCESS;
                        st_d      = ST_STOP;
                    end else if (inst_q.fin) begin
                        stop_set  = 1'b1;
                        stop_code = (pc_q == EXIT_PC) ? ERR_NONE : ERR_EXIT;
                        st_d      = ST_STOP;
                    end else begin
                        st_d = ST_FETCH;
                    end
                end
            end
            default: st_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_FETCH;
            pc_q     <= BOOT_PC;
            inst_q   <= '0;
            a_q      <= '0;
            b_q      <= '0;
            c_q      <= '0;
            f_q      <= 1'b0;
            hold_c_q <= '0;
            hold_f_q <= 1'b0;
            step_q   <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_FETCH && !budget_out && rom_ack) begin
                inst_q <= inst_dec;
            end
            if (st_q == ST_OPA && opnd_ack && !opnd_fault) begin
                a_q <= opnd_data;
            end
            if (st_q == ST_OPB && opnd_ack && !opnd_fault) begin
                b_q <= opnd_data;
            end
            if (st_q == ST_EXEC && exe_ack) begin
                c_q <= exe_c;
                f_q <= exe_flag;
            end
            if (st_q == ST_COMMIT && wb_ack && !wb_fault) begin
                hold_c_q <= c_q;
                hold_f_q <= f_q;
                step_q   <= step_q + 1'b1;
                if (!inst_q.fin) begin
                    pc_q <= pc_nxt;
                end
            end
        end
    end

    assign rom_req   = (st_q == ST_FETCH) && !budget_out;
    assign rom_addr  = pc_q;
    assign inst_out  = inst_q;
    assign opnd_req  = (st_q == ST_OPA) || (st_q == ST_OPB);
    assign opnd_sel  = (st_q == ST_OPB);
    assign a_out     = a_q;
    assign prev_c    = hold_c_q;
    assign prev_flag = hold_f_q;
    assign step_cnt  = step_q;
    assign exe_req   = (st_q == ST_EXEC);
    assign exe_op    = inst_q.op;
    assign exe_a     = a_q;
    assign exe_b     = b_q;
    assign wb_req    = (st_q == ST_COMMIT);
    assign wb_data   = c_q;
    assign pc_out    = pc_q;
    assign err_code  = status_code;

endmodule

// File: rtl/seqr_checker.sv
module seqr_checker import seqr_pkg::*; #(
    parameter logic [ADDR_W-1:0] BOOT_PC   = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] EXIT_PC   = 32'h0000_1100,
    parameter int                MAX_STEPS = 1024,
    parameter int                NUM_OPS   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rom_req,
    input logic              rom_ack,
    input logic              rom_hit,
    input logic [OP_W-1:0]   rom_op,
    input logic [INST_W-1:0] inst_out,
    input logic              opnd_req,
    input logic              exe_req,
    input logic              exe_ack,
    input logic              wb_req,
    input logic              wb_ack,
    input logic              wb_fault,
    input logic [XLEN-1:0]   prev_c,
    input logic              prev_flag,
    input logic [STEP_W-1:0] step_cnt,
    input logic [ADDR_W-1:0] pc_out,
    input logic              done,
    input logic              success,
    input logic [2:0]        err_code
);

    inst_t cur;
    logic  commit_ok;

    assign cur       = inst_t'(inst_out);
    assign commit_ok = wb_req && wb_ack && !wb_fault;

    assert_boot_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_out == BOOT_PC && step_cnt == '0 && prev_c == '0 && !prev_flag && !done));

    assert_one_request_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_req, opnd_req, exe_req, wb_req}));

    assert_fetch_held_R2: assert property (@(posedge clk) disable iff (rst)
        (rom_req && !rom_ack) |=> rom_req);

    assert_exec_held_R2: assert property (@(posedge clk) disable iff (rst)
        (exe_req && !exe_ack) |=> exe_req);

    assert_branch_target_R3: assert property (@(posedge clk) disable iff (rst)
        (commit_ok && !cur.fin && !cur.rel) |=>
        (pc_out == (prev_flag ? $past(pc_out) + $past(cur.kt) : $past(pc_out) + $past(cur.kf))));

    assert_jump_target_R3: assert property (@(posedge clk) disable iff (rst)
        (commit_ok && !cur.fin && cur.rel) |=> (pc_out == prev_c[ADDR_W-1:0] + $past(cur.kj)));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !commit_ok |=> ($stable(prev_c) && $stable(prev_flag)));

    assert_step_inc_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(step_cnt) |-> (step_cnt == $past(step_cnt) + 1'b1));

    assert_success_at_exit_R6: assert property (@(posedge clk) disable iff (rst)
        success |-> (pc_out == EXIT_PC && err_code == 3'd0));

    assert_halt_stops_R7: assert property (@(posedge clk) disable iff (rst)
        (rom_req && rom_ack && rom_hit && rom_op == OP_HALT) |=> (done && err_code == 3'd1));

    assert_legal_in_flight_R8: assert property (@(posedge clk) disable iff (rst)
        opnd_req |-> (int'(cur.op) < NUM_OPS));

    assert_budget_R10: assert property (@(posedge clk) disable iff (rst)
        step_cnt <= STEP_W'(MAX_STEPS));

    assert_quiet_done_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !(rom_req || opnd_req || exe_req || wb_req));

    assert_status_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && $stable(err_code) && $stable(success)));

endmodule

bind step_sequencer seqr_checker #(
    .BOOT_PC   (BOOT_PC),
    .EXIT_PC   (EXIT_PC),
    .MAX_STEPS (MAX_STEPS),
    .NUM_OPS   (NUM_OPS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rom_req   (rom_req),
    .rom_ack   (rom_ack),
    .rom_hit   (rom_hit),
    .rom_op    (rom_data[seqr_pkg::INST_W-1 -: seqr_pkg::OP_W]),
    .inst_out  (inst_out),
    .opnd_req  (opnd_req),
    .exe_req   (exe_req),
    .exe_ack   (exe_ack),
    .wb_req    (wb_req),
    .wb_ack    (wb_ack),
    .wb_fault  (wb_fault),
    .prev_c    (prev_c),
    .prev_flag (prev_flag),
    .step_cnt  (step_cnt),
    .pc_out    (pc_out),
    .done      (done),
    .success   (success),
    .err_code  (err_code)
);

// File: tb/step_sequencer_tb.sv
`timescale 1ns/1ps
module step_sequencer_tb;
    import seqr_pkg::*;

    localparam logic [31:0] BOOT  = 32'h0000_1000;
    localparam logic [31:0] EXITA = 32'h0000_1100;
    localparam int          MAXS  = 64;
    localparam int          NOPS  = 16;
    localparam int          TN    = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rom_req, rom_ack, rom_hit;
    logic [31:0] rom_addr;
    logic [INST_W-1:0] rom_data, inst_out;
    logic opnd_req, opnd_sel, opnd_ack, opnd_fault;
    logic [63:0] opnd_data, a_out, prev_c;
    logic prev_flag;
    logic [31:0] step_cnt, pc_out;
    logic exe_req, exe_ack, exe_flag;
    logic [7:0] exe_op;
    logic [63:0] exe_a, exe_b, exe_c;
    logic wb_req, wb_ack, wb_fault;
    logic [63:0] wb_data;
    logic done, success;
    logic [2:0] err_code;

    always #2.5 clk = ~clk;

    step_sequencer #(.BOOT_PC(BOOT), .EXIT_PC(EXITA), .MAX_STEPS(MAXS), .NUM_OPS(NOPS)) u_dut (
        .clk(clk), .rst(rst), .rom_req(rom_req), .rom_addr(rom_addr), .rom_ack(rom_ack),
        .rom_hit(rom_hit), .rom_data(rom_data), .inst_out(inst_out), .opnd_req(opnd_req),
        .opnd_sel(opnd_sel), .opnd_ack(opnd_ack), .opnd_fault(opnd_fault), .opnd_data(opnd_data),
        .a_out(a_out), .prev_c(prev_c), .prev_flag(prev_flag), .step_cnt(step_cnt),
        .exe_req(exe_req), .exe_op(exe_op), .exe_a(exe_a), .exe_b(exe_b), .exe_ack(exe_ack),
        .exe_c(exe_c), .exe_flag(exe_flag), .wb_req(wb_req), .wb_data(wb_data), .wb_ack(wb_ack),
        .wb_fault(wb_fault), .pc_out(pc_out), .done(done), .success(success), .err_code(err_code)
    );

    // Program table used both by the ROM responder and by the predictor
    logic [31:0] t_addr [TN];
    inst_t       t_ins  [TN];
    logic [63:0] t_a    [TN];
    logic [63:0] t_b    [TN];
    logic        t_af   [TN];
    logic        t_wf   [TN];
    int          t_n;

    typedef struct {
        logic        fin;
        logic [31:0] addr;
        logic [31:0] step;
        logic [63:0] hc;
        logic        hf;
        logic [2:0]  code;
    } exp_t;

    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    logic done_seen = 1'b0;
    logic lag = 1'b0;
    logic held = 1'b0;
    logic [63:0] last_c = '0;

    function automatic int find_ins(input logic [31:0] ad);
        for (int i = 0; i < t_n; i++) begin
            if (t_addr[i] == ad) return i;
        end
        return -1;
    endfunction

    // Environment model of the operation unit
    function automatic logic [63:0] op_c(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b);
        if (op == 8'd0) return b;
        if (op == 8'd1) return a + b;
        return a ^ b;
    endfunction

    function automatic logic op_f(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b);
        if (op == 8'd0) return 1'b0;
        if (op == 8'd1) return (a < b);
        return a[0];
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        t_n = 0;
    endtask

    task automatic add_ins(input logic [31:0] ad, input logic [7:0] op, input logic fin, input logic rel,
                           input logic [31:0] kj, input logic [31:0] kt, input logic [31:0] kf,
                           input logic [63:0] a, input logic [63:0] b, input logic af, input logic wf);
        t_addr[t_n] = ad;
        t_ins[t_n]  = '{op: op, fin: fin, rel: rel, kj: kj, kt: kt, kf: kf};
        t_a[t_n]    = a;
        t_b[t_n]    = b;
        t_af[t_n]   = af;
        t_wf[t_n]   = wf;
        t_n++;
    endtask

    // Driver side: walk the program by the requirements and queue expectations
    task automatic predict();
        logic [31:0] p = BOOT;
        logic [63:0] hc = '0;
        logic        hf = 1'b0;
        logic [31:0] s = '0;
        logic [2:0]  code = 3'd0;
        logic [63:0] c;
        logic        f;
        int          ix;
        bit          stop = 0;
        exp_t        e;
        while (!stop) begin
            if (s == 32'(MAXS)) begin
                code = 3'd4; stop = 1;                       // R10
            end else begin
                e = '{fin: 1'b0, addr: p, step: s, hc: hc, hf: hf, code: 3'd0};
                sb.push_back(e);
                ix = find_ins(p);
                if (ix < 0) begin
                    code = 3'd2; stop = 1;                   // R8 miss
                end else if (t_ins[ix].op == 8'h3F) begin
                    code = 3'd1; stop = 1;                   // R7
                end else if (int'(t_ins[ix].op) >= NOPS) begin
                    code = 3'd2; stop = 1;                   // R8 opcode
                end else if (t_af[ix]) begin
                    code = 3'd3; stop = 1;                   // R9 operand
                end else begin
                    c = op_c(t_ins[ix].op, t_a[ix], t_b[ix]);
                    f = op_f(t_ins[ix].op, t_a[ix], t_b[ix]);
                    if (t_wf[ix]) begin
                        code = 3'd3; stop = 1;               // R9 commit
                    end else begin
                        hc = c; hf = f; s = s + 1;           // R4, R5
                        if (t_ins[ix].fin) begin
                            code = (p == EXITA) ? 3'd0 : 3'd5; stop = 1;   // R6
                        end else if (t_ins[ix].rel) begin
                            p = c[31:0] + t_ins[ix].kj;      // R3
                        end else begin
                            p = f ? p + t_ins[ix].kt : p + t_ins[ix].kf;
                        end
                    end
                end
            end
        end
        e = '{fin: 1'b1, addr: p, step: s, hc: hc, hf: hf, code: code};
        sb.push_back(e);
    endtask

    // Responders and monitor, all at the falling edge
    always @(negedge clk) begin
        int   ix;
        exp_t e;
        rom_ack = 1'b0; rom_hit = 1'b0; opnd_ack = 1'b0; opnd_fault = 1'b0;
        exe_ack = 1'b0; wb_ack = 1'b0; wb_fault = 1'b0;
        if (!rst) begin
            if (rom_req) begin
                if (lag && !held) begin
                    held = 1'b1;
                end else begin
                    held = 1'b0;
                    ix = find_ins(rom_addr);
                    rom_ack  = 1'b1;
                    rom_hit  = (ix >= 0);
                    rom_data = (ix >= 0) ? t_ins[ix] : '0;
                    if (sb.size() == 0 || sb[0].fin) begin
                        chk(1'b0, "R2", "unexpected fetch", {32'h0, rom_addr}, 64'h0);
                    end else begin
                        e = sb.pop_front();
                        chk(rom_addr == e.addr, "R3", "fetch address", {32'h0, rom_addr}, {32'h0, e.addr});
                        chk(step_cnt == e.step, "R5", "step at fetch", {32'h0, step_cnt}, {32'h0, e.step});
                        chk(prev_c == e.hc, "R4", "held result", prev_c, e.hc);
                        chk(prev_flag == e.hf, "R4", "held flag", {63'h0, prev_flag}, {63'h0, e.hf});
                    end
                end
            end
            if (opnd_req) begin
                ix = find_ins(pc_out);
                opnd_ack = 1'b1;
                if (ix >= 0) begin
                    opnd_data  = opnd_sel ? t_b[ix] : t_a[ix];
                    opnd_fault = t_af[ix];
                end
            end
            if (exe_req) begin
                ix = find_ins(pc_out);
                if (ix >= 0) begin
                    chk(exe_a == t_a[ix], "R2", "operand a to op", exe_a, t_a[ix]);
                    chk(exe_b == t_b[ix], "R2", "operand b to op", exe_b, t_b[ix]);
                end
                exe_c    = op_c(exe_op, exe_a, exe_b);
                exe_flag = op_f(exe_op, exe_a, exe_b);
                last_c   = exe_c;
                exe_ack  = 1'b1;
            end
            if (wb_req) begin
                ix = find_ins(pc_out);
                chk(wb_data == last_c, "R2", "commit data", wb_data, last_c);
                wb_ack = 1'b1;
                if (ix >= 0) wb_fault = t_wf[ix];
            end
            if (done && !done_seen) begin
                done_seen = 1'b1;
                if (sb.size() != 1 || !sb[0].fin) begin
                    chk(1'b0, "R11", "stop point", 64'(sb.size()), 64'd1);
                    sb.delete();
                end else begin
                    e = sb.pop_front();
                    chk(err_code == e.code, "R11", "error code", {61'h0, err_code}, {61'h0, e.code});
                    chk(success == (e.code == 3'd0), "R6", "success", {63'h0, success}, {63'h0, e.code == 3'd0});
                    chk(step_cnt == e.step, "R5", "final steps", {32'h0, step_cnt}, {32'h0, e.step});
                    chk(pc_out == e.addr, "R6", "final pc", {32'h0, pc_out}, {32'h0, e.addr});
                    chk(prev_c == e.hc, "R9", "final held result", prev_c, e.hc);
                end
            end
        end
    end

    task automatic run_prog(input logic slow);
        logic [2:0] want;
        @(negedge clk);
        rst = 1'b1;
        lag = slow;
        held = 1'b0;
        done_seen = 1'b0;
        sb.delete();
        predict();
        want = sb[sb.size()-1].code;
        repeat (4) @(negedge clk);
        chk(pc_out == BOOT, "R1", "reset pc", {32'h0, pc_out}, {32'h0, BOOT});
        chk(step_cnt == 0 && prev_c == 0 && !prev_flag && !done, "R1", "reset state",
            {31'h0, done, step_cnt}, 64'h0);
        rst = 1'b0;
        while (!done_seen) @(posedge clk);
        repeat (6) @(negedge clk);
        chk(done && err_code == want, "R11", "status held", {60'h0, done, err_code}, {60'h0, 1'b1, want});
        chk(!(rom_req || opnd_req || exe_req || wb_req), "R10", "no request after stop",
            {60'h0, rom_req, opnd_req, exe_req, wb_req}, 64'h0);
        chk(sb.size() == 0, "R2", "scoreboard drained", 64'(sb.size()), 64'h0);
    endtask

    initial begin
        rom_data = '0; opnd_data = '0; exe_c = '0; exe_flag = 1'b0;
        rom_ack = 1'b0; rom_hit = 1'b0; opnd_ack = 1'b0; opnd_fault = 1'b0;
        exe_ack = 1'b0; wb_ack = 1'b0; wb_fault = 1'b0;

        // R3 R6: taken branch, fall-through branch, relative jump, final at exit
        clear_prog();
        add_ins(32'h1000, 8'd1, 0, 0, 32'h0,  32'h10, 32'h4,  64'd5, 64'd7, 0, 0);
        add_ins(32'h1010, 8'd1, 0, 0, 32'h0,  32'h8,  32'h20, 64'd9, 64'd3, 0, 0);
        add_ins(32'h1030, 8'd1, 0, 1, 32'h80, 32'h4,  32'h4,  64'h1000, 64'h80, 0, 0);
        add_ins(32'h1100, 8'd0, 1, 0, 32'h0,  32'h4,  32'h4,  64'd0, 64'h55, 0, 0);
        run_prog(1'b1);

        // R7: halt sentinel after one step
        clear_prog();
        add_ins(32'h1000, 8'd1, 0, 0, 32'h0, 32'h4, 32'h4, 64'd1, 64'd1, 0, 0);
        add_ins(32'h1004, 8'h3F, 0, 0, 32'h0, 32'h4, 32'h4, 64'd0, 64'd0, 0, 0);
        run_prog(1'b0);

        // R8: jump to an address with no instruction
        clear_prog();
        add_ins(32'h1000, 8'd1, 0, 1, 32'h0, 32'h4, 32'h4, 64'h2000, 64'd0, 0, 0);
        run_prog(1'b0);

        // R8: opcode outside the legal range
        clear_prog();
        add_ins(32'h1000, 8'h20, 0, 0, 32'h0, 32'h4, 32'h4, 64'd0, 64'd0, 0, 0);
        run_prog(1'b0);

        // R9: operand access fault on the first step
        clear_prog();
        add_ins(32'h1000, 8'd1, 0, 0, 32'h0, 32'h4, 32'h4, 64'd3, 64'd4, 1, 0);
        run_prog(1'b0);

        // R9: commit fault on the second step keeps the first step's state
        clear_prog();
        add_ins(32'h1000, 8'd1, 0, 0, 32'h0, 32'h4, 32'h4, 64'd20, 64'd22, 0, 0);
        add_ins(32'h1004, 8'd2, 0, 0, 32'h0, 32'h4, 32'h4, 64'd6, 64'd3, 0, 1);
        run_prog(1'b0);

        // R6 R3: backward offset then final away from the exit address
        clear_prog();
        add_ins(32'h1000, 8'd1, 0, 0, 32'h0, 32'h10, 32'h4,        64'd1, 64'd2, 0, 0);
        add_ins(32'h1010, 8'd1, 0, 0, 32'h0, 32'h4,  32'hFFFF_FFF8, 64'd3, 64'd1, 0, 0);
        add_ins(32'h1008, 8'd0, 1, 0, 32'h0, 32'h4,  32'h4,        64'd0, 64'd9, 0, 0);
        run_prog(1'b0);

        // R10: self loop exhausts the step budget
        clear_prog();
        add_ins(32'h1000, 8'd1, 0, 0, 32'h0, 32'h0, 32'h0, 64'd0, 64'd0, 0, 0);
        run_prog(1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule